// File: doc/BRIEF.md
# I2C Byte-Addressed Register Memory Target

This block is an I2C target that puts a 256-byte register array behind a single 7-bit device address. The array is outside the block and is reached through a simple port: a combinational read from the pointed-to location and a single-cycle write strobe. An 8-bit byte pointer selects the location. The pointer survives from one bus transaction to the next, so a read that carries no word address continues where the last access stopped.

A master reads the byte at the pointer by sending the address with R/W=1. To read from a chosen location, it first sends a write header with a word-address byte, then a repeated start and a read header. Each byte the master acknowledges is followed by the next byte, and the pointer wraps from FFh to 00h. A single-byte write is committed at the stop condition. It then starts a self-timed write cycle. While that cycle runs, the block will not acknowledge its own address, so the master polls with address headers until it gets an ACK.

SCL and SDA are brought in through a two-flop synchroniser. Start and stop are detected as SDA edges while SCL is high. SDA is open-drain: `sda_o` is always 0, and `sda_oe_o` pulls the line low.

Top module: `i2c_regmem_slave`

## Requirements
- R1: After reset the block releases SDA (`sda_oe_o`=0), raises no write strobe, and the pointer is 00h, so the first read with no word address returns the byte at 00h.
- R2: A header whose upper seven bits equal DEV_ADDR is acknowledged by SDA low during the ninth SCL pulse, for R/W=0 and for R/W=1. The word-address byte that follows a write header is also acknowledged.
- R3: A write header plus a word-address byte, then a repeated start and a read header, returns the byte at that word address.
- R4: A read with no word address returns the byte at the pointer. The pointer is one past the last byte read or written, and it is kept across transactions.
- R5: In a read, every byte the master acknowledges is followed by the byte at the next address. The pointer steps from FFh to 00h.
- R6: When the master does not acknowledge a read byte, the block releases SDA and leaves it released for any further SCL pulses, until the next start or stop.
- R7: A write of one data byte is committed at the stop condition as a one-cycle `mem_we_o` pulse, with `mem_addr_o` set to the word address and `mem_wdata_o` set to the data. The pointer then holds word address plus one.
- R8: For WRITE_CYCLES clocks after the write strobe, the device address is not acknowledged, SDA is never driven, and no further write strobe occurs. After that window the address is acknowledged again.
- R9: A header with a different address is not acknowledged. All later bytes up to the next start are ignored: no ACK and no write.
- R10: A second data byte in the same write transaction is not acknowledged. It is not stored; the first byte is still committed at the stop.
- R11: Read data is sent MSB first, and the block changes SDA only while SCL is low.
- R12: A write transaction that stops after the word address loads the pointer. It stores nothing and starts no write cycle, so the next header is acknowledged at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_o | output | 1 | Data output value, always 0 (open drain) |
| sda_oe_o | output | 1 | Drive enable; 1 pulls SDA low |
| mem_addr_o | output | 8 | Array address (the byte pointer) |
| mem_wdata_o | output | 8 | Write data for the array |
| mem_we_o | output | 1 | One-cycle array write strobe |
| mem_rdata_i | input | 8 | Array read data at `mem_addr_o` |

## Verification
The bench builds the block with DEV_ADDR=7'h50 and WRITE_CYCLES=1000, with each SCL half period set to 20 system clocks. A 1000-clock write window is longer than one address header but shorter than three. The first poll after a write is therefore always refused, and a later poll in the same test is accepted, so both sides of the busy window are seen. Because the pointer is a full 8 bits, a random read loaded at FDh reaches the FFh-to-00h wrap within one sequential read.

// File: rtl/i2c_regmem_pkg.sv
package i2c_regmem_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned BIT_CNT_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_WAIT
  } bus_st_e;

  typedef enum logic [1:0] {
    RX_DEV,
    RX_WADDR,
    RX_WDATA
  } rx_kind_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d, scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  assign scl_s      = scl_ff[STAGES-1];
  assign sda_s      = sda_ff[STAGES-1];
  assign sda_lvl_o  = sda_s;
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  // SDA edge with SCL held high
  assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_wr_timer.sv
module i2c_wr_timer #(
  parameter int unsigned CYCLES = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/i2c_regmem_slave.sv
module i2c_regmem_slave
  import i2c_regmem_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR     = 7'h50,
  parameter int unsigned WRITE_CYCLES = 5000,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_o,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  input  logic [BYTE_W-1:0] mem_rdata_i
);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W);

  logic sda_s, scl_rise, scl_fall, bus_start, bus_stop, busy;

  bus_st_e              state_q;
  rx_kind_e             kind_q;
  logic [BIT_CNT_W-1:0] cnt_q;
  logic [BYTE_W-1:0]    shreg_q, tx_q, ptr_q, wdata_q;
  logic                 have_data_q, ack_q, rw_q, mack_q, we_q;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_lvl_o  (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (bus_start),
    .stop_o     (bus_stop)
  );

  i2c_wr_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (we_q),
    .busy_o (busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      kind_q      <= RX_DEV;
      cnt_q       <= '0;
      shreg_q     <= '0;
      tx_q        <= '0;
      ptr_q       <= '0;
      wdata_q     <= '0;
      have_data_q <= 1'b0;
      ack_q       <= 1'b0;
      rw_q        <= 1'b0;
      mack_q      <= 1'b0;
      we_q        <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (we_q) ptr_q <= ptr_q + 8'd1;
      if (bus_stop) begin
        state_q     <= ST_IDLE;
        we_q        <= have_data_q;
        have_data_q <= 1'b0;
      end else if (bus_start) begin
        state_q     <= ST_RX;
        kind_q      <= RX_DEV;
        cnt_q       <= '0;
        have_data_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_RX: begin
            if (scl_rise) begin
              shreg_q <= {shreg_q[BYTE_W-2:0], sda_s};
              cnt_q   <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == LAST_BIT) begin
              cnt_q   <= '0;
              state_q <= ST_ACK;
              unique case (kind_q)
                RX_DEV: begin
                  ack_q <= (shreg_q[7:1] == DEV_ADDR) && !busy;
                  rw_q  <= shreg_q[0];
                end
                RX_WADDR: begin
                  ack_q <= 1'b1;
                  ptr_q <= shreg_q;
                end
                default: begin
                  // only one data byte per write
                  ack_q <= !have_data_q;
                  if (!have_data_q) begin
                    wdata_q     <= shreg_q;
                    have_data_q <= 1'b1;
                  end
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              cnt_q <= '0;
              if (!ack_q) begin
                state_q <= ST_WAIT;
              end else if (kind_q == RX_DEV && rw_q) begin
                tx_q    <= mem_rdata_i;
                state_q <= ST_TX;
              end else begin
                state_q <= ST_RX;
                kind_q  <= (kind_q == RX_DEV) ? RX_WADDR : RX_WDATA;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall) begin
              if (cnt_q == LAST_BIT) begin
                state_q <= ST_MACK;
                ptr_q   <= ptr_q + 8'd1;
              end else begin
                tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack_q <= !sda_s;
            end else if (scl_fall) begin
              if (mack_q) begin
                tx_q    <= mem_rdata_i;
                cnt_q   <= '0;
                state_q <= ST_TX;
              end else begin
                state_q <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_o       = 1'b0;
  assign sda_oe_o    = (state_q == ST_ACK && ack_q) || (state_q == ST_TX && !tx_q[BYTE_W-1]);
  assign mem_addr_o  = ptr_q;
  assign mem_wdata_o = wdata_q;
  assign mem_we_o    = we_q;
endmodule

// File: rtl/i2c_regmem_chk.sv
module i2c_regmem_chk #(
  parameter int unsigned WRITE_CYCLES = 5000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic sda_i,
  input logic sda_oe_o,
  input logic mem_we_o
);
  localparam int unsigned CW = $clog2(WRITE_CYCLES + 1);

  logic [CW-1:0] win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           win_q <= '0;
    else if (mem_we_o)     win_q <= CW'(WRITE_CYCLES);
    else if (win_q != '0)  win_q <= win_q - 1'b1;
  end

  // R7
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);

  // R7
  we_at_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (scl_i && sda_i));

  // R8
  busy_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_q != '0) |-> !sda_oe_o);

  // R8
  busy_no_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_q != '0) |-> !mem_we_o);

  // R11
  drive_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);
endmodule

bind i2c_regmem_slave i2c_regmem_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_i    (scl_i),
  .sda_i    (sda_i),
  .sda_oe_o (sda_oe_o),
  .mem_we_o (mem_we_o)
);

// File: tb/sim_i2c_regmem_slave.sv
module sim_i2c_regmem_slave;
  localparam logic [6:0] DEV  = 7'h50;
  localparam int         WC   = 1000;
  localparam int         HALF = 20;
  localparam logic [7:0] HW   = {DEV, 1'b0};
  localparam logic [7:0] HR   = {DEV, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_o_w, sda_oe_w, mem_we;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic [7:0] exp_ptr = 8'h00;
  logic [7:0] last_we_addr = '0, last_we_data = '0;
  int we_cnt = 0, n_chk = 0, n_bad = 0;
  bit done = 0;
  wire bus_sda = sda_m & ~(sda_oe_w & ~sda_o_w);

  always #5 clk = ~clk;

  i2c_regmem_slave #(.DEV_ADDR(DEV), .WRITE_CYCLES(WC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(bus_sda),
    .sda_o(sda_o_w), .sda_oe_o(sda_oe_w), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_we_o(mem_we), .mem_rdata_i(mem_rdata));

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37) ^ 8'h5A);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(i);
    end else if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
    end
  end
  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (rst_n && mem_we) begin
      we_cnt       <= we_cnt + 1;
      last_we_addr <= mem_addr;
      last_we_data <= mem_wdata;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(HALF); scl_m = 1'b1; tick(HALF);
    sda_m = 1'b0; tick(HALF); scl_m = 1'b0; tick(HALF);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(HALF); scl_m = 1'b1; tick(HALF);
    sda_m = 1'b1; tick(HALF);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(HALF/2); scl_m = 1'b1; tick(HALF); scl_m = 1'b0; tick(HALF/2);
    end
    sda_m = 1'b1; tick(HALF/2); scl_m = 1'b1; tick(HALF/2);
    ack = !bus_sda;
    tick(HALF/2); scl_m = 1'b0; tick(HALF/2);
  endtask

  task automatic get_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      tick(HALF/2); scl_m = 1'b1; tick(HALF/2);
      b = {b[6:0], bus_sda};
      tick(HALF/2); scl_m = 1'b0; tick(HALF/2);
    end
    sda_m = !mack; tick(HALF/2); scl_m = 1'b1; tick(HALF); scl_m = 1'b0; tick(HALF/2);
    sda_m = 1'b1;
  endtask

  task automatic t_reset();
    logic a; logic [7:0] b;
    chk("R1 sda released", sda_oe_w, 0);
    chk("R1 no strobe", mem_we, 0);
    bus_start(); put_byte(HR, a);
    chk("R2 read header ack", a, 1);
    get_byte(1'b0, b); bus_stop();
    chk("R1 first byte at 00h", b, exp_mem[0]);
    exp_ptr = 8'h01;
  endtask

  task automatic t_random();
    logic a; logic [7:0] b;
    bus_start(); put_byte(HW, a); chk("R2 write header ack", a, 1);
    put_byte(8'h37, a); chk("R2 word address ack", a, 1);
    bus_start(); put_byte(HR, a); chk("R3 read header ack", a, 1);
    get_byte(1'b0, b); bus_stop();
    chk("R3 R11 random read byte", b, exp_mem[8'h37]);
    exp_ptr = 8'h38;
  endtask

  task automatic t_current();
    logic a; logic [7:0] b;
    bus_start(); put_byte(HR, a); get_byte(1'b0, b); bus_stop();
    chk("R4 current read byte", b, exp_mem[exp_ptr]);
    exp_ptr++;
  endtask

  task automatic t_seq_wrap();
    logic a; logic [7:0] b;
    bus_start(); put_byte(HW, a); put_byte(8'hFD, a);
    bus_start(); put_byte(HR, a);
    for (int i = 0; i < 5; i++) begin
      get_byte(i < 4, b);
      chk("R5 sequential byte", b, exp_mem[8'(8'hFD + i)]);
    end
    bus_stop();
    exp_ptr = 8'h02;
    bus_start(); put_byte(HR, a); get_byte(1'b0, b); bus_stop();
    chk("R5 pointer after wrap", b, exp_mem[8'h02]);
    exp_ptr = 8'h03;
  endtask

  task automatic t_nack_release();
    logic a; logic [7:0] b;
    bus_start(); put_byte(HR, a); get_byte(1'b0, b);
    exp_ptr++;
    for (int i = 0; i < 9; i++) begin
      tick(HALF/2); scl_m = 1'b1; tick(HALF/2);
      chk("R6 released after master nack", bus_sda, 1);
      tick(HALF/2); scl_m = 1'b0; tick(HALF/2);
    end
    bus_stop();
  endtask

  task automatic t_wrong_addr();
    logic a; logic [7:0] b; int w0;
    w0 = we_cnt;
    bus_start(); put_byte({7'h51, 1'b0}, a); chk("R9 foreign header nack", a, 0);
    put_byte(8'h00, a); chk("R9 following byte ignored", a, 0);
    put_byte(HR, a); chk("R9 own header without start ignored", a, 0);
    bus_stop(); tick(4);
    chk("R9 no write", we_cnt, w0);
    bus_start(); put_byte(HR, a); get_byte(1'b0, b); bus_stop();
    chk("R9 pointer untouched", b, exp_mem[exp_ptr]);
    exp_ptr++;
  endtask

  task automatic t_write_poll();
    logic a, got; logic [7:0] b; int w0;
    w0 = we_cnt;
    bus_start(); put_byte(HW, a); put_byte(8'h80, a);
    put_byte(8'h5C, a); chk("R7 data byte ack", a, 1);
    bus_stop(); tick(2);
    chk("R7 one strobe", we_cnt, w0 + 1);
    chk("R7 strobe address", last_we_addr, 8'h80);
    chk("R7 strobe data", last_we_data, 8'h5C);
    exp_mem[8'h80] = 8'h5C;
    bus_start(); put_byte(HW, a); bus_stop();
    chk("R8 first poll refused", a, 0);
    got = 1'b0;
    for (int i = 0; i < 6 && !got; i++) begin
      bus_start(); put_byte(HW, a); bus_stop();
      got = a;
    end
    chk("R8 poll accepted after window", got, 1);
    chk("R8 no extra strobe", we_cnt, w0 + 1);
    bus_start(); put_byte(HR, a); get_byte(1'b0, b); bus_stop();
    chk("R7 pointer is address plus one", b, exp_mem[8'h81]);
    bus_start(); put_byte(HW, a); put_byte(8'h80, a);
    bus_start(); put_byte(HR, a); get_byte(1'b0, b); bus_stop();
    chk("R7 stored byte read back", b, 8'h5C);
    exp_ptr = 8'h81;
  endtask

  task automatic t_extra_byte();
    logic a; logic [7:0] b; int w0;
    w0 = we_cnt;
    bus_start(); put_byte(HW, a); put_byte(8'h10, a);
    put_byte(8'h11, a); chk("R10 first data ack", a, 1);
    put_byte(8'h22, a); chk("R10 second data nack", a, 0);
    bus_stop(); tick(WC + 50);
    chk("R10 single strobe", we_cnt, w0 + 1);
    exp_mem[8'h10] = 8'h11;
    bus_start(); put_byte(HW, a); put_byte(8'h10, a);
    bus_start(); put_byte(HR, a); get_byte(1'b1, b);
    chk("R10 first byte stored", b, 8'h11);
    get_byte(1'b0, b); bus_stop();
    chk("R10 second byte not stored", b, exp_mem[8'h11]);
    exp_ptr = 8'h12;
  endtask

  task automatic t_stop_early();
    logic a; logic [7:0] b; int w0;
    w0 = we_cnt;
    bus_start(); put_byte(HW, a); put_byte(8'hC4, a); bus_stop();
    bus_start(); put_byte(HR, a);
    chk("R12 header acked at once", a, 1);
    get_byte(1'b0, b); bus_stop();
    chk("R12 pointer loaded", b, exp_mem[8'hC4]);
    chk("R12 no write", we_cnt, w0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) exp_mem[i] = pat(i);
    tick(5); rst_n = 1'b1; tick(5);
    t_reset();
    t_random();
    t_current();
    t_seq_wrap();
    t_nack_release();
    t_wrong_addr();
    t_write_poll();
    t_extra_byte();
    t_stop_early();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule